// File: doc/BRIEF.md
# Prioritized Maskable Interrupt Controller

This block gathers level-sensitive interrupt requests from peripherals and presents them to a processor on two lines: a normal request line and a fast request line. Sources are grouped in banks of 32. Each bank has an enable register and a route register. Pending state is never latched: a request is seen while its peripheral holds it high and disappears as soon as the peripheral lets go.

A programmable table of priority slots lets software pick which pending normal-line source to service first. Each slot names one source and carries a valid flag. The controller scans the slots every cycle, lowest slot first, and registers the winner in a highest-priority word. That word carries a valid flag and the source number. A wake line tells a sleeping core that something is pending. A control bit chooses whether disabled sources may also wake the core.

Software reaches every register through a word-addressed read/write port. Writes take effect at the clock edge. Reads are combinational.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, every enable word, route word and priority slot reads 0, and the control word reads 0. With all sources high, both request lines then stay low and the highest-priority word reads 0.
- R2: The normal-line pending word of a bank (word address 8*bank+0) equals raw AND enable AND NOT route. `irqOut` is the OR of all normal-line pending bits.
- R3: The fast-line pending word of a bank (word address 8*bank+3) equals raw AND enable AND route. A route bit of 1 selects the fast line. `fiqOut` is the OR of all fast-line pending bits.
- R4: The enable word of a bank is at word address 8*bank+1, and a bit of 1 enables that source. Writing 0 to it disables every source in that bank at once. The route word is at 8*bank+2.
- R5: Priority slot s is at word address 0x100+s. Bit 31 is the slot's valid flag and bits 6:0 are the source number. It reads back exactly as written, with all other bits 0.
- R6: The highest-priority word (word address 0x081) holds bit 31 = valid and bits 30:16 = source number. The winner is the lowest-numbered valid slot whose source is normal-line pending. The word reads 0 when no slot qualifies. It is updated at the clock edge after its inputs change.
- R7: Control word (word address 0x080) bit 0 = 0 means any raw source drives `wakeOut`. Bit 0 = 1 means only enabled sources drive it, whichever line they are routed to.
- R8: The raw word of a bank (word address 8*bank+4) mirrors `srcIn` in the same cycle, with no latching. A source that drops clears its pending state at once.
- R9: Writes to the pending, raw and highest-priority words change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| srcIn | input | NUM_SRC | Level-sensitive interrupt requests |
| wrEn | input | 1 | Register write strobe |
| wordAddr | input | 10 | Register word address |
| wrData | input | 32 | Register write data |
| rdData | output | 32 | Register read data, combinational from `wordAddr` |
| irqOut | output | 1 | Normal interrupt request |
| fiqOut | output | 1 | Fast interrupt request |
| wakeOut | output | 1 | Idle wake request |

## Verification
The request lines, the wake line and every pending or raw word are combinational. A change on `srcIn` shows on them at once. A register write shows from the edge that performs it. The highest-priority word needs one more edge after its inputs settle, so the bench changes sources on a falling edge, lets one rising edge pass, and reads at the next falling edge. One directed test reads the word just before that edge and again just after it, to confirm the one-cycle lag.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
  localparam int MAX_BANKS = 4;
  localparam int ID_W = 7;
  localparam int WADDR_W = 10;
  localparam logic [WADDR_W-1:0] CTRL_WADDR = 10'h080;
  localparam logic [WADDR_W-1:0] HIGH_WADDR = 10'h081;

  typedef enum logic [3:0] {
    RD_NONE, RD_IRQ, RD_MASK, RD_LEVEL, RD_FIQ, RD_RAW, RD_CTRL, RD_HIGH, RD_PRIO
  } rdKind_e;

  typedef struct packed {
    logic [MAX_BANKS-1:0] maskWe;
    logic [MAX_BANKS-1:0] levelWe;
    logic                 ctrlWe;
    logic                 prioWe;
    rdKind_e              rdKind;
    logic [ID_W-1:0]      idx;
  } strobe_t;
endpackage

// File: rtl/prio_irq_decode.sv
module prio_irq_decode
  import prio_irq_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  parameter int NUM_SLOTS = 64
) (
  input  logic               wrEn,
  input  logic [WADDR_W-1:0] wordAddr,
  output strobe_t            stb
);
  logic [1:0]      bankSel;
  logic [ID_W-1:0] slotSel;

  assign bankSel = wordAddr[4:3];
  assign slotSel = wordAddr[6:0];

  always_comb begin
    stb = '0;
    stb.rdKind = RD_NONE;
    if (wordAddr[9:5] == 5'd0) begin
      if (int'(bankSel) < NUM_BANKS) begin
        stb.idx = {5'd0, bankSel};
        case (wordAddr[2:0])
          3'd0: stb.rdKind = RD_IRQ;
          3'd1: begin
            stb.rdKind = RD_MASK;
            stb.maskWe[bankSel] = wrEn;
          end
          3'd2: begin
            stb.rdKind = RD_LEVEL;
            stb.levelWe[bankSel] = wrEn;
          end
          3'd3: stb.rdKind = RD_FIQ;
          3'd4: stb.rdKind = RD_RAW;
          default: stb.rdKind = RD_NONE;
        endcase
      end
    end else if (wordAddr == CTRL_WADDR) begin
      stb.rdKind = RD_CTRL;
      stb.ctrlWe = wrEn;
    end else if (wordAddr == HIGH_WADDR) begin
      stb.rdKind = RD_HIGH;
    end else if (wordAddr[9:7] == 3'b010) begin
      if (int'(slotSel) < NUM_SLOTS) begin
        stb.rdKind = RD_PRIO;
        stb.prioWe = wrEn;
        stb.idx = slotSel;
      end
    end
  end
endmodule

// File: rtl/prio_irq_datapath.sv
module prio_irq_datapath
  import prio_irq_pkg::*;
#(
  parameter int NUM_SRC = 64
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcIn,
  input  strobe_t            stb,
  input  logic [31:0]        wrData,
  output logic [31:0]        rdData,
  output logic               irqOut,
  output logic               fiqOut,
  output logic               wakeOut,
  output logic               hpValid,
  output logic [ID_W-1:0]    hpId
);
  localparam int NUM_BANKS = NUM_SRC / 32;
  localparam int SRC_W = $clog2(NUM_SRC);

  logic [31:0]        maskQ  [NUM_BANKS];
  logic [31:0]        levelQ [NUM_BANKS];
  logic [NUM_SRC-1:0] maskFlat, levelFlat, irqPend, fiqPend;
  logic               prioValidQ [NUM_SRC];
  logic [ID_W-1:0]    prioIdQ    [NUM_SRC];
  logic               ctrlQ;
  logic               winFound;
  logic [ID_W-1:0]    winId;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        maskQ[b]  <= '0;
        levelQ[b] <= '0;
      end else begin
        if (stb.maskWe[b])  maskQ[b]  <= wrData;
        if (stb.levelWe[b]) levelQ[b] <= wrData;
      end
    end
    assign maskFlat[b*32 +: 32]  = maskQ[b];
    assign levelFlat[b*32 +: 32] = levelQ[b];
  end

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_slot
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        prioValidQ[s] <= 1'b0;
        prioIdQ[s]    <= '0;
      end else if (stb.prioWe && stb.idx == ID_W'(s)) begin
        prioValidQ[s] <= wrData[31];
        prioIdQ[s]    <= wrData[ID_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          ctrlQ <= 1'b0;
    else if (stb.ctrlWe) ctrlQ <= wrData[0];
  end

  assign irqPend = srcIn & maskFlat & ~levelFlat;
  assign fiqPend = srcIn & maskFlat & levelFlat;
  assign irqOut  = |irqPend;
  assign fiqOut  = |fiqPend;
  assign wakeOut = ctrlQ ? |(srcIn & maskFlat) : |srcIn;

  // lowest valid slot with a normal-line pending source wins
  always_comb begin
    winFound = 1'b0;
    winId    = '0;
    for (int s = NUM_SRC - 1; s >= 0; s--) begin
      if (prioValidQ[s] && int'(prioIdQ[s]) < NUM_SRC &&
          irqPend[prioIdQ[s][SRC_W-1:0]]) begin
        winFound = 1'b1;
        winId    = prioIdQ[s];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hpValid <= 1'b0;
      hpId    <= '0;
    end else begin
      hpValid <= winFound;
      hpId    <= winFound ? winId : '0;
    end
  end

  always_comb begin
    rdData = '0;
    case (stb.rdKind)
      RD_IRQ, RD_MASK, RD_LEVEL, RD_FIQ, RD_RAW: begin
        for (int b = 0; b < NUM_BANKS; b++) begin
          if (stb.idx == ID_W'(b)) begin
            case (stb.rdKind)
              RD_IRQ:   rdData = irqPend[b*32 +: 32];
              RD_MASK:  rdData = maskQ[b];
              RD_LEVEL: rdData = levelQ[b];
              RD_FIQ:   rdData = fiqPend[b*32 +: 32];
              default:  rdData = srcIn[b*32 +: 32];
            endcase
          end
        end
      end
      RD_CTRL: rdData = {31'd0, ctrlQ};
      RD_HIGH: rdData = {hpValid, 8'd0, hpId, 16'd0};
      RD_PRIO: begin
        for (int s = 0; s < NUM_SRC; s++) begin
          if (stb.idx == ID_W'(s)) rdData = {prioValidQ[s], 24'd0, prioIdQ[s]};
        end
      end
      default: rdData = '0;
    endcase
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import prio_irq_pkg::*;
#(
  parameter int NUM_SRC = 64
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcIn,
  input  logic               wrEn,
  input  logic [9:0]         wordAddr,
  input  logic [31:0]        wrData,
  output logic [31:0]        rdData,
  output logic               irqOut,
  output logic               fiqOut,
  output logic               wakeOut
);
  localparam int NUM_BANKS = NUM_SRC / 32;

  strobe_t         stb;
  logic            hpValid;
  logic [ID_W-1:0] hpId;

  prio_irq_decode #(.NUM_BANKS(NUM_BANKS), .NUM_SLOTS(NUM_SRC)) u_decode (
    .wrEn(wrEn), .wordAddr(wordAddr), .stb(stb)
  );

  prio_irq_datapath #(.NUM_SRC(NUM_SRC)) u_datapath (
    .clk(clk), .rstN(rstN), .srcIn(srcIn), .stb(stb), .wrData(wrData),
    .rdData(rdData), .irqOut(irqOut), .fiqOut(fiqOut), .wakeOut(wakeOut),
    .hpValid(hpValid), .hpId(hpId)
  );
endmodule

// File: rtl/prio_irq_ctrl_chk.sv
module prio_irq_ctrl_chk #(
  parameter int NUM_SRC = 64
) (
  input logic               clk,
  input logic               rstN,
  input logic [NUM_SRC-1:0] srcIn,
  input logic               irqOut,
  input logic               fiqOut,
  input logic               wakeOut,
  input logic               hpValid
);
  assert_irq_needs_src_R2: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> (|srcIn));

  assert_fiq_needs_src_R3: assert property (@(posedge clk) disable iff (!rstN)
    fiqOut |-> (|srcIn));

  assert_wake_covers_req_R7: assert property (@(posedge clk) disable iff (!rstN)
    !wakeOut |-> (!irqOut && !fiqOut));

  assert_idle_no_winner_R6: assert property (@(posedge clk) disable iff (!rstN)
    !(|srcIn) |=> !hpValid);

  assert_winner_was_pending_R6: assert property (@(posedge clk) disable iff (!rstN)
    hpValid |-> $past(irqOut));
endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk #(.NUM_SRC(NUM_SRC)) u_chk (
  .clk(clk), .rstN(rstN), .srcIn(srcIn), .irqOut(irqOut),
  .fiqOut(fiqOut), .wakeOut(wakeOut), .hpValid(hpValid)
);

// File: tb/prio_irq_ctrl_test.sv
module prio_irq_ctrl_test;
  localparam int NUM_SRC = 64;

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic [NUM_SRC-1:0] srcIn = '0;
  logic               wrEn = 1'b0;
  logic [9:0]         wordAddr = '0;
  logic [31:0]        wrData = '0;
  logic [31:0]        rdData;
  logic               irqOut, fiqOut, wakeOut;

  int checks = 0;
  int errors = 0;
  logic [31:0] rd;

  always #10 clk = ~clk;

  prio_irq_ctrl #(.NUM_SRC(NUM_SRC)) uut (
    .clk(clk), .rstN(rstN), .srcIn(srcIn), .wrEn(wrEn), .wordAddr(wordAddr),
    .wrData(wrData), .rdData(rdData), .irqOut(irqOut), .fiqOut(fiqOut),
    .wakeOut(wakeOut)
  );

  typedef struct packed {
    logic [63:0] src;
    logic [31:0] mask0;
    logic [31:0] level0;
    logic        irq;
    logic        fiq;
    logic        wake;
    logic [31:0] high;
  } vec_t;

  // slot0->5, slot1->40, slot2->3, slot3 invalid->1, slot4->1; bank1 enables src 40
  localparam vec_t VECS [8] = '{
    '{64'h0,                   32'hFFFF_FFFF, 32'h0,  1'b0, 1'b0, 1'b0, 32'h0},
    '{64'h0A,                  32'hFFFF_FFFF, 32'h0,  1'b1, 1'b0, 1'b1, 32'h8003_0000},
    '{64'h0000_0100_0000_0028, 32'hFFFF_FFFF, 32'h0,  1'b1, 1'b0, 1'b1, 32'h8005_0000},
    '{64'h0000_0100_0000_0028, 32'hFFFF_FFFF, 32'h20, 1'b1, 1'b1, 1'b1, 32'h8028_0000},
    '{64'h20,                  32'hFFFF_FFFF, 32'h20, 1'b0, 1'b1, 1'b1, 32'h0},
    '{64'h02,                  32'hFFFF_FFFF, 32'h0,  1'b1, 1'b0, 1'b1, 32'h8001_0000},
    '{64'h08,                  32'h0,         32'h0,  1'b0, 1'b0, 1'b1, 32'h0},
    '{64'h80,                  32'hFFFF_FFFF, 32'h0,  1'b1, 1'b0, 1'b1, 32'h0}
  };

  vec_t v;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk);
    wordAddr = a;
    wrData = d;
    wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic regRead(input logic [9:0] a, output logic [31:0] d);
    wordAddr = a;
    #1;
    d = rdData;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // R1 reset state, sources all high
    srcIn = '1;
    @(negedge clk);
    @(negedge clk);
    regRead(10'h001, rd); check("R1 mask0", rd, 0);
    regRead(10'h00A, rd); check("R1 level1", rd, 0);
    regRead(10'h080, rd); check("R1 ctrl", rd, 0);
    regRead(10'h100, rd); check("R1 slot0", rd, 0);
    regRead(10'h081, rd); check("R1 high", rd, 0);
    check("R1 irqOut", irqOut, 0);
    check("R1 fiqOut", fiqOut, 0);
    check("R7 wake raw ctrl0", wakeOut, 1);
    srcIn = '0;

    // configure table
    regWrite(10'h100, 32'h8000_0005);
    regWrite(10'h101, 32'h8000_0028);
    regWrite(10'h102, 32'h8000_0003);
    regWrite(10'h103, 32'h0000_0001);
    regWrite(10'h104, 32'h8000_0001);
    regWrite(10'h009, 32'h0000_0100);
    regRead(10'h100, rd); check("R5 slot0 readback", rd, 32'h8000_0005);
    regRead(10'h103, rd); check("R5 slot3 invalid readback", rd, 32'h0000_0001);
    regWrite(10'h105, 32'hFFFF_FFFF);
    regRead(10'h105, rd); check("R5 slot5 other bits zero", rd, 32'h8000_007F);
    regWrite(10'h105, 32'h0);

    // R2 R3 R6 vector table
    for (int i = 0; i < 8; i++) begin
      v = VECS[i];
      regWrite(10'h001, v.mask0);
      regWrite(10'h002, v.level0);
      @(negedge clk);
      srcIn = v.src;
      @(negedge clk);
      check($sformatf("R2 irqOut vec%0d", i), irqOut, v.irq);
      check($sformatf("R3 fiqOut vec%0d", i), fiqOut, v.fiq);
      check($sformatf("R7 wakeOut vec%0d", i), wakeOut, v.wake);
      regRead(10'h081, rd);
      check($sformatf("R6 high vec%0d", i), rd, v.high);
      regRead(10'h000, rd);
      check($sformatf("R2 irq word vec%0d", i), rd, v.src[31:0] & v.mask0 & ~v.level0);
      regRead(10'h003, rd);
      check($sformatf("R3 fiq word vec%0d", i), rd, v.src[31:0] & v.mask0 & v.level0);
    end

    // R8 raw mirrors input, no latching
    regWrite(10'h001, 32'hFFFF_FFFF);
    regWrite(10'h002, 32'h0);
    @(negedge clk);
    srcIn = 64'h0000_0100_0000_0008;
    #1;
    regRead(10'h004, rd); check("R8 raw bank0", rd, 32'h8);
    regRead(10'h00C, rd); check("R8 raw bank1", rd, 32'h100);
    @(negedge clk);
    srcIn = '0;
    #1;
    regRead(10'h004, rd); check("R8 raw drops", rd, 0);
    check("R8 irq drops", irqOut, 0);

    // R6 one-cycle lag of highest word
    @(negedge clk);
    srcIn = 64'h8;
    regRead(10'h081, rd); check("R6 high before edge", rd, 0);
    @(negedge clk);
    regRead(10'h081, rd); check("R6 high after edge", rd, 32'h8003_0000);

    // R9 writes to read-only words ignored
    regWrite(10'h081, 32'hFFFF_FFFF);
    regWrite(10'h000, 32'h0);
    regWrite(10'h004, 32'hFFFF_FFFF);
    regRead(10'h081, rd); check("R9 high unchanged", rd, 32'h8003_0000);
    regRead(10'h000, rd); check("R9 irq word unchanged", rd, 32'h8);
    regRead(10'h004, rd); check("R9 raw unchanged", rd, 32'h8);
    regRead(10'h001, rd); check("R9 mask unchanged", rd, 32'hFFFF_FFFF);

    // R4 clearing the enable word disables the whole bank
    srcIn = 64'h0000_0000_FFFF_FFFF;
    @(negedge clk);
    check("R4 irq before clear", irqOut, 1);
    regWrite(10'h001, 32'h0);
    check("R4 irq after clear", irqOut, 0);
    regRead(10'h000, rd); check("R4 irq word after clear", rd, 0);

    // R7 control bit 1 gates wake by enables
    regWrite(10'h080, 32'h1);
    srcIn = 64'h8;
    #1;
    check("R7 wake masked", wakeOut, 0);
    regWrite(10'h002, 32'h8);
    regWrite(10'h001, 32'h8);
    check("R7 wake enabled fast", wakeOut, 1);
    check("R7 fast line", fiqOut, 1);
    regWrite(10'h080, 32'h0);
    regWrite(10'h001, 32'h0);
    check("R7 wake raw again", wakeOut, 1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule